// File: doc/BRIEF.md
# Host Port Service Request Generator

This block sits on the DSP side of a parallel host port and tells an external host processor when the port needs attention. It watches two host-facing conditions. The first is that a word is waiting for the host to read. The second is that there is room for the host to write a word. Each condition is gated by its own enable bit in the host-side control field. A separate DSP-side enable and a stop-mode input gate both conditions together.

A host-side split bit chooses how requests reach the host. With the bit clear, one shared active-low line carries both kinds of request, and the second line is parked high. With the bit set, the first line carries only the read request and the second line carries only the write request.

In parallel, the block raises two active-high DMA request levels, one for each data direction, from the DSP-side register status. These levels only serve on-chip memory transfers to and from the port's data registers. They cause no host bus activity, so the host still learns of new data only through the request lines or by polling. Every output is registered.

Top module: `hostreq_gen`

## Requirements
- R1: While reset is asserted and after it is released, `req_a_n` and `req_b_n` are high and `dma_rx_req` and `dma_tx_req` are low until input-driven values are registered.
- R2: With `host_ctrl[2]`=0 (shared mode), `req_a_n` is low exactly when (`host_ctrl[0]` and `host_rd_avail`) or (`host_ctrl[1]` and `host_wr_space`) holds, and `req_b_n` stays high.
- R3: With `host_ctrl[2]`=1 (split mode), `req_a_n` is low exactly when `host_ctrl[0]` and `host_rd_avail` both hold, and `req_b_n` is low exactly when `host_ctrl[1]` and `host_wr_space` both hold.
- R4: When `dsp_req_en` is 0, `req_a_n` and `req_b_n` are both high, whatever the status and the host-side control bits are.
- R5: When `stop_mode` is 1, both request lines are high and both DMA request levels are low.
- R6: `dma_rx_req` is high exactly when `dsp_rx_full` and `dma_rx_en` are both 1, and `dma_tx_req` is high exactly when `dsp_tx_empty` and `dma_tx_en` are both 1. Neither depends on `dsp_req_en` or on `host_ctrl`.
- R7: Each output reflects the inputs sampled at the previous rising clock edge. A request therefore drops one clock after its status or enable is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_mode | input | 1 | Port isolated; forces all requests inactive |
| dsp_req_en | input | 1 | DSP-side enable for host request lines |
| host_ctrl | input | 3 | Host-side control: bit0 read-request enable, bit1 write-request enable, bit2 split mode |
| host_rd_avail | input | 1 | A word is waiting for the host to read |
| host_wr_space | input | 1 | The port can accept a host write |
| dsp_rx_full | input | 1 | DSP-side receive register holds data |
| dsp_tx_empty | input | 1 | DSP-side transmit register is empty |
| dma_rx_en | input | 1 | DMA enable, receive direction |
| dma_tx_en | input | 1 | DMA enable, transmit direction |
| req_a_n | output | 1 | Shared request (shared mode) or read request (split mode), active low |
| req_b_n | output | 1 | Write request in split mode, held high in shared mode, active low |
| dma_rx_req | output | 1 | Receive-direction DMA request level |
| dma_tx_req | output | 1 | Transmit-direction DMA request level |

## Verification
Every output has a single register between the inputs and the port. Each result is therefore due exactly one rising edge after its stimulus, and this holds for enables, mode changes, stop mode and status alike. The bench changes inputs on the falling edge and checks on the following falling edge. That places each sample one full edge after the stimulus was captured and half a period away from any update. The reset checks sample while reset is held, and again one cycle after reset is applied in mid-run with every input active.

// File: rtl/hostreq_pkg.sv
package hostreq_pkg;

    localparam int CTRL_W      = 3;
    localparam int CTL_RD_EN   = 0;
    localparam int CTL_WR_EN   = 1;
    localparam int CTL_SPLIT   = 2;
    localparam int DMA_CH      = 2;
    localparam int DMA_RX_IDX  = 0;
    localparam int DMA_TX_IDX  = 1;

    typedef struct packed {
        logic                req_a_n;
        logic                req_b_n;
        logic [DMA_CH-1:0]   dma_req;
    } hreq_state_t;

    localparam hreq_state_t HREQ_IDLE = '{req_a_n: 1'b1, req_b_n: 1'b1, dma_req: '0};

endpackage

// File: rtl/hreq_line_map.sv
module hreq_line_map (
    input  logic active,
    input  logic split,
    input  logic rd_cond,
    input  logic wr_cond,
    output logic line_a,
    output logic line_b
);
    always_comb begin
        if (!active) begin
            line_a = 1'b0;
            line_b = 1'b0;
        end else if (split) begin
            line_a = rd_cond;
            line_b = wr_cond;
        end else begin
            line_a = rd_cond | wr_cond;
            line_b = 1'b0;
        end
    end
endmodule

// File: rtl/dma_req_gate.sv
module dma_req_gate #(
    parameter int N = 2
) (
    input  logic         isolate,
    input  logic [N-1:0] status,
    input  logic [N-1:0] enable,
    output logic [N-1:0] req
);
    for (genvar g = 0; g < N; g++) begin : g_ch
        assign req[g] = !isolate && status[g] && enable[g];
    end
endmodule

// File: rtl/hostreq_gen.sv
module hostreq_gen
    import hostreq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stop_mode,
    input  logic              dsp_req_en,
    input  logic [CTRL_W-1:0] host_ctrl,
    input  logic              host_rd_avail,
    input  logic              host_wr_space,
    input  logic              dsp_rx_full,
    input  logic              dsp_tx_empty,
    input  logic              dma_rx_en,
    input  logic              dma_tx_en,
    output logic              req_a_n,
    output logic              req_b_n,
    output logic              dma_rx_req,
    output logic              dma_tx_req
);
    hreq_state_t state_d, state_q;

    logic              host_active;
    logic              rd_cond, wr_cond;
    logic              line_a, line_b;
    logic [DMA_CH-1:0] dma_status, dma_enable, dma_req;

    assign host_active = dsp_req_en && !stop_mode;
    assign rd_cond     = host_ctrl[CTL_RD_EN] && host_rd_avail;
    assign wr_cond     = host_ctrl[CTL_WR_EN] && host_wr_space;

    hreq_line_map u_map (
        .active  (host_active),
        .split   (host_ctrl[CTL_SPLIT]),
        .rd_cond (rd_cond),
        .wr_cond (wr_cond),
        .line_a  (line_a),
        .line_b  (line_b)
    );

    always_comb begin
        dma_status             = '0;
        dma_enable             = '0;
        dma_status[DMA_RX_IDX] = dsp_rx_full;
        dma_status[DMA_TX_IDX] = dsp_tx_empty;
        dma_enable[DMA_RX_IDX] = dma_rx_en;
        dma_enable[DMA_TX_IDX] = dma_tx_en;
    end

    dma_req_gate #(.N(DMA_CH)) u_dma (
        .isolate (stop_mode),
        .status  (dma_status),
        .enable  (dma_enable),
        .req     (dma_req)
    );

    always_comb begin
        state_d         = state_q;
        state_d.req_a_n = !line_a;
        state_d.req_b_n = !line_b;
        state_d.dma_req = dma_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HREQ_IDLE;
        else        state_q <= state_d;
    end

    assign req_a_n    = state_q.req_a_n;
    assign req_b_n    = state_q.req_b_n;
    assign dma_rx_req = state_q.dma_req[DMA_RX_IDX];
    assign dma_tx_req = state_q.dma_req[DMA_TX_IDX];

    a_r4_dsp_enable_gates: assert property (@(posedge clk) disable iff (!rst_n)
        !dsp_req_en |=> (req_a_n && req_b_n));

    a_r2_shared_parks_b: assert property (@(posedge clk) disable iff (!rst_n)
        !host_ctrl[CTL_SPLIT] |=> req_b_n);

    a_r5_stop_isolates: assert property (@(posedge clk) disable iff (!rst_n)
        stop_mode |=> (req_a_n && req_b_n && !dma_rx_req && !dma_tx_req));

    a_r3_split_read_line: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ctrl[CTL_SPLIT] && dsp_req_en && !stop_mode && host_ctrl[CTL_RD_EN] && host_rd_avail)
        |=> !req_a_n);

    a_r7_rd_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_rd_avail && !(host_ctrl[CTL_WR_EN] && host_wr_space)) |=> req_a_n);

    a_r6_dma_tx_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_tx_en |=> !dma_tx_req);

    a_r6_dma_rx_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_rx_en |=> !dma_rx_req);

endmodule

// File: tb/hostreq_gen_tb.sv
module hostreq_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       stop_mode, dsp_req_en;
    logic [2:0] host_ctrl;
    logic       host_rd_avail, host_wr_space, dsp_rx_full, dsp_tx_empty;
    logic       dma_rx_en, dma_tx_en;
    logic       req_a_n, req_b_n, dma_rx_req, dma_tx_req;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    hostreq_gen dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .stop_mode     (stop_mode),
        .dsp_req_en    (dsp_req_en),
        .host_ctrl     (host_ctrl),
        .host_rd_avail (host_rd_avail),
        .host_wr_space (host_wr_space),
        .dsp_rx_full   (dsp_rx_full),
        .dsp_tx_empty  (dsp_tx_empty),
        .dma_rx_en     (dma_rx_en),
        .dma_tx_en     (dma_tx_en),
        .req_a_n       (req_a_n),
        .req_b_n       (req_b_n),
        .dma_rx_req    (dma_rx_req),
        .dma_tx_req    (dma_tx_req)
    );

    // Stimulus {stop,dsp_en,ctrl[2:0],rd,wr,rxf,txe,drx_en,dtx_en}, expect {a_n,b_n,drx,dtx}
    localparam int NV = 14;
    localparam logic [14:0] VEC [NV] = '{
        15'b0_1_000_1_1_0_0_0_0_1_1_0_0,  // R2 no host enables
        15'b0_1_001_1_0_0_0_0_0_0_1_0_0,  // R2 read condition on shared line
        15'b0_1_010_1_0_0_0_0_0_1_1_0_0,  // R2/R7 write enabled but no space, read drops
        15'b0_1_010_0_1_0_0_0_0_0_1_0_0,  // R2 write condition on shared line
        15'b0_0_011_1_1_0_0_0_0_1_1_0_0,  // R4 DSP enable clear
        15'b0_1_111_1_1_0_0_0_0_0_0_0_0,  // R3 split, both lines
        15'b0_1_101_1_1_0_0_0_0_0_1_0_0,  // R3 split, read only
        15'b0_1_110_1_1_0_0_0_0_1_0_0_0,  // R3 split, write only
        15'b0_1_110_1_0_0_0_0_0_1_1_0_0,  // R3/R7 write space removed
        15'b1_1_111_1_1_1_1_1_1_1_1_0_0,  // R5 stop isolates all
        15'b0_0_000_0_0_1_1_1_1_1_1_1_1,  // R6 both DMA levels
        15'b0_0_000_0_0_1_0_1_1_1_1_1_0,  // R6 receive only
        15'b0_0_000_0_0_1_1_0_1_1_1_0_1,  // R6 transmit only
        15'b0_1_011_1_1_1_1_1_1_0_1_1_1   // R2/R6 shared with DMA
    };

    task automatic drive(input logic [10:0] s);
        {stop_mode, dsp_req_en, host_ctrl, host_rd_avail, host_wr_space,
         dsp_rx_full, dsp_tx_empty, dma_rx_en, dma_tx_en} = s;
    endtask

    task automatic check(input logic [3:0] exp, input string req);
        logic [3:0] act;
        act = {req_a_n, req_b_n, dma_rx_req, dma_tx_req};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: outputs {a_n,b_n,drx,dtx} actual=%b expected=%b", req, act, exp);
        end
    endtask

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        drive(11'b0_1_111_1_1_1_1_1_1);
        repeat (3) @(negedge clk);
        check(4'b1100, "R1 reset state");
        rst_n = 1'b1;
        drive('0);
        @(negedge clk);
        check(4'b1100, "R1 idle after reset");

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][14:4]);
            @(negedge clk);
            check(VEC[i][3:0], $sformatf("R7 vector %0d", i));
        end

        // R7: one-cycle latency, value not yet visible before the edge
        drive(11'b0_1_001_1_0_0_0_0_0);
        @(negedge clk);
        drive(11'b0_1_001_0_0_0_0_0_0);
        #1 check(4'b0100, "R7 held before edge");
        @(negedge clk);
        check(4'b1100, "R7 drop one clock after status clears");

        // R5: stop exit restores request
        drive(11'b1_1_101_1_0_0_0_0_0);
        @(negedge clk);
        check(4'b1100, "R5 stop held");
        drive(11'b0_1_101_1_0_0_0_0_0);
        @(negedge clk);
        check(4'b0100, "R5 stop exit");

        // R1: mid-run reset with all inputs active
        drive(11'b0_1_111_1_1_1_1_1_1);
        @(negedge clk);
        check(4'b0011, "R3 all active");
        rst_n = 1'b0;
        #1 check(4'b1100, "R1 mid-run reset");
        @(negedge clk);
        check(4'b1100, "R1 reset held");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule